// File: doc/BRIEF.md
# Transmit/Receive DMA Burst Sequencer

This block shares one internal bus between a transmit DMA channel and a receive DMA channel. Each channel raises a request together with the number of 32-bit long words it wants moved. The sequencer picks a winner and announces a burst with a one-cycle start strobe, the channel it belongs to, and its beat count. It then passes that many data beats from its input stream to its output stream. Transfers longer than the burst limit are cut into several bursts, and the two channels are arbitrated again between bursts.

The burst limit comes from an encoded setting. Codes that are one power of two give bursts of 1 to 32 long words. Code zero falls back to a separate cache-alignment length. Any other code is reserved: it raises a flag and gives single-beat bursts. There are two arbitration modes. In one, receive always wins. In the other, the grant alternates between the channels. A byte-order setting can reverse the four bytes of every beat on its way through.

The data path uses valid/ready handshakes. Outside a burst, `in_ready` and `out_valid` are both low. Inside a burst, a beat moves only in a cycle where `in_valid` and `out_ready` are both high. The ready and valid signals are passed straight through, so a stall on either side stops both sides at once. An upstream source must hold `in_data` steady while `in_valid` is high and no beat has moved.

Top module: `dma_burst_seq`

## Requirements
- R1: A burst code of 6'h01, 6'h02, 6'h04, 6'h08, 6'h10 or 6'h20 limits each burst to 1, 2, 4, 8, 16 or 32 long words respectively.
- R2: Burst code 6'h00 takes the limit from `cache_words`; a `cache_words` value of 0 gives a limit of 1.
- R3: Any other burst code drives `code_bad` high and gives bursts of exactly 1 beat; `code_bad` is low for the codes listed in R1 and R2.
- R4: With `fair_mode` = 0, if the receive channel is requesting at a grant decision it gets the grant, even when transmit is also requesting.
- R5: With `fair_mode` = 1 and both channels requesting, grants alternate between the channels. After reset, the first such grant goes to transmit.
- R6: Each burst has min(remaining words, limit) beats. Bursts follow one another until the requested count is used up. The channel's done output (`tx_done` or `rx_done`) then pulses for one cycle, and the requester must drop its request in that cycle.
- R7: With `big_endian` = 1, `out_data` is `in_data` with its four bytes in reverse order; with `big_endian` = 0 it is `in_data` unchanged.
- R8: `out_valid` and `in_ready` are low outside a burst. Inside a burst, `out_valid` = `in_valid` and `in_ready` = `out_ready`. `out_last` marks the final beat of each burst.
- R9: `burst_start` pulses for one cycle per burst, with `burst_rx` (1 = receive) and `burst_beats`. After reset, `burst_start`, `out_valid`, `in_ready` and both done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Transmit channel requests a transfer |
| tx_words | input | 16 | Transmit transfer length in long words (nonzero) |
| rx_req | input | 1 | Receive channel requests a transfer |
| rx_words | input | 16 | Receive transfer length in long words (nonzero) |
| fair_mode | input | 1 | 1 = alternate grants, 0 = receive first |
| big_endian | input | 1 | 1 = reverse the byte order of each beat |
| burst_code | input | 6 | Encoded burst length setting |
| cache_words | input | 7 | Fallback burst limit for code 0 |
| code_bad | output | 1 | Burst code is reserved |
| burst_start | output | 1 | One-cycle strobe at the start of each burst |
| burst_rx | output | 1 | Current burst belongs to the receive channel |
| burst_beats | output | 7 | Beat count of the current burst |
| tx_done | output | 1 | Transmit transfer complete pulse |
| rx_done | output | 1 | Receive transfer complete pulse |
| in_data | input | 32 | Input beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| out_data | output | 32 | Output beat, byte order per `big_endian` |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_last | output | 1 | Final beat of the current burst |

## Verification
The properties assume the following about the inputs. Requested lengths are nonzero. A requester keeps its request and length steady until its done pulse, then drops the request during that pulse. `burst_code` and `fair_mode` do not change around a grant decision. The bench drives requests, lengths and mode settings only between transfers, and releases each request on the first falling edge at which it sees the done pulse. It applies random stalls to `in_valid` and `out_ready` so the back-pressure rules are exercised while those assumptions still hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_e;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
endpackage

// File: rtl/burst_limit_decode.sv
module burst_limit_decode #(
  parameter int CODE_W = 6,
  parameter int LIM_W  = 7,
  parameter int NPOW   = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [LIM_W-1:0]  cache_words,
  output logic [LIM_W-1:0]  limit,
  output logic              reserved
);
  // one-hot codes map to their own power of two; zero defers to cache length
  always_comb begin
    reserved = 1'b0;
    limit    = LIM_W'(1);
    if (code == '0) begin
      limit = (cache_words == '0) ? LIM_W'(1) : cache_words;
    end else begin
      reserved = 1'b1;
      for (int i = 0; i < NPOW; i++) begin
        if (code == CODE_W'(1 << i)) begin
          limit    = LIM_W'(1 << i);
          reserved = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic want_tx,
  input  logic want_rx,
  input  logic fair,
  input  logic take,
  output logic grant_rx,
  output logic any
);
  logic last_rx;

  assign any      = want_tx | want_rx;
  // receive wins unless fair mode hands the turn to transmit
  assign grant_rx = want_rx & (~fair | ~want_tx | ~last_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_rx <= 1'b1;
    else if (take) last_rx <= grant_rx;
  end
endmodule

// File: rtl/byte_order_swap.sv
module byte_order_swap #(
  parameter int BYTES = 4
) (
  input  logic             swap,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  logic [8*BYTES-1:0] rev;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign rev[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end

  assign dout = swap ? rev : din;
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int LEN_W  = 16,
  parameter int CODE_W = 6,
  parameter int LIM_W  = 7,
  parameter int BYTES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  input  logic [LEN_W-1:0]   tx_words,
  input  logic               rx_req,
  input  logic [LEN_W-1:0]   rx_words,
  input  logic               fair_mode,
  input  logic               big_endian,
  input  logic [CODE_W-1:0]  burst_code,
  input  logic [LIM_W-1:0]   cache_words,
  output logic               code_bad,
  output logic               burst_start,
  output logic               burst_rx,
  output logic [LIM_W-1:0]   burst_beats,
  output logic               tx_done,
  output logic               rx_done,
  input  logic [8*BYTES-1:0] in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic [8*BYTES-1:0] out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_last
);
  import burst_seq_pkg::*;

  localparam int DATA_W = 8 * BYTES;

  seq_state_e           state;
  logic [LIM_W-1:0]     beats_left;
  logic [1:0]           busy;
  logic [LEN_W-1:0]     left_tx, left_rx;
  logic [LIM_W-1:0]     limit;
  logic                 want_tx, want_rx, grant_rx, any_want, take;
  logic [LEN_W-1:0]     avail, limit_ext, n_full;
  logic [LIM_W-1:0]     n_beats;
  logic                 fire, in_burst;
  logic [LEN_W-1:0]     left_cur;

  burst_limit_decode #(.CODE_W(CODE_W), .LIM_W(LIM_W), .NPOW(6)) u_dec (
    .code        (burst_code),
    .cache_words (cache_words),
    .limit       (limit),
    .reserved    (code_bad)
  );

  assign want_tx = tx_req & ~tx_done;
  assign want_rx = rx_req & ~rx_done;
  assign take    = (state == SEQ_IDLE) & any_want;

  rr_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_tx  (want_tx),
    .want_rx  (want_rx),
    .fair     (fair_mode),
    .take     (take),
    .grant_rx (grant_rx),
    .any      (any_want)
  );

  // words still owed to the winner: a fresh transfer starts from its length
  always_comb begin
    if (grant_rx) avail = busy[CH_RX] ? left_rx : rx_words;
    else          avail = busy[CH_TX] ? left_tx : tx_words;
    limit_ext = LEN_W'(limit);
    n_full    = (avail < limit_ext) ? avail : limit_ext;
    n_beats   = n_full[LIM_W-1:0];
  end

  assign in_burst  = (state == SEQ_BURST);
  assign out_valid = in_burst & in_valid;
  assign in_ready  = in_burst & out_ready;
  assign fire      = out_valid & out_ready;
  assign out_last  = in_burst & (beats_left == LIM_W'(1));
  assign left_cur  = burst_rx ? left_rx : left_tx;

  byte_order_swap #(.BYTES(BYTES)) u_swap (
    .swap (big_endian),
    .din  (in_data),
    .dout (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      beats_left  <= '0;
      busy        <= '0;
      left_tx     <= '0;
      left_rx     <= '0;
      burst_start <= 1'b0;
      burst_rx    <= 1'b0;
      burst_beats <= '0;
      tx_done     <= 1'b0;
      rx_done     <= 1'b0;
    end else begin
      burst_start <= 1'b0;
      tx_done     <= 1'b0;
      rx_done     <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (take) begin
            state       <= SEQ_BURST;
            burst_start <= 1'b1;
            burst_rx    <= grant_rx;
            burst_beats <= n_beats;
            beats_left  <= n_beats;
            if (grant_rx) begin
              busy[CH_RX] <= 1'b1;
              left_rx     <= avail - n_full;
            end else begin
              busy[CH_TX] <= 1'b1;
              left_tx     <= avail - n_full;
            end
          end
        end
        SEQ_BURST: begin
          if (fire) begin
            if (beats_left == LIM_W'(1)) begin
              state <= SEQ_IDLE;
              if (left_cur == '0) begin
                if (burst_rx) begin
                  rx_done     <= 1'b1;
                  busy[CH_RX] <= 1'b0;
                end else begin
                  tx_done     <= 1'b1;
                  busy[CH_TX] <= 1'b0;
                end
              end
            end
            beats_left <= beats_left - LIM_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  logic [DATA_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
  parameter int CODE_W = 6,
  parameter int LIM_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_req,
  input logic              fair_mode,
  input logic [CODE_W-1:0] burst_code,
  input logic              code_bad,
  input logic              burst_start,
  input logic              burst_rx,
  input logic [LIM_W-1:0]  burst_beats,
  input logic              tx_done,
  input logic              rx_done,
  input logic              out_valid
);
  // R9: the start strobe never lasts two cycles
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  // R6: every burst carries at least one beat
  assert_beats_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> burst_beats != '0);

  // R6: only one channel finishes per cycle
  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, rx_done}));

  // R3: a reserved code at the grant decision yields a single-beat burst
  assert_reserved_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && $past(code_bad)) |-> burst_beats == LIM_W'(1));

  // R1: code 4 never yields more than four beats
  assert_limit_four_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && $past(burst_code) == CODE_W'(4)) |-> burst_beats <= LIM_W'(4));

  // R4: in receive-first mode a pending receive request takes the grant
  assert_rx_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && $past(!fair_mode && rx_req && !rx_done)) |-> burst_rx);

  // R8: no beat is offered in the cycle a transfer reports completion
  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_done) |-> !out_valid);
endmodule

bind dma_burst_seq burst_seq_checker #(.CODE_W(CODE_W), .LIM_W(LIM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_req      (rx_req),
  .fair_mode   (fair_mode),
  .burst_code  (burst_code),
  .code_bad    (code_bad),
  .burst_start (burst_start),
  .burst_rx    (burst_rx),
  .burst_beats (burst_beats),
  .tx_done     (tx_done),
  .rx_done     (rx_done),
  .out_valid   (out_valid)
);

// File: tb/sim_dma_burst_seq.sv
module sim_dma_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_req = 1'b0, rx_req = 1'b0;
  logic [15:0] tx_words = '0, rx_words = '0;
  logic        fair_mode = 1'b0, big_endian = 1'b0;
  logic [5:0]  burst_code = 6'h01;
  logic [6:0]  cache_words = 7'd0;
  logic        code_bad, burst_start, burst_rx, tx_done, rx_done;
  logic [6:0]  burst_beats;
  logic [31:0] in_data = '0, out_data;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, out_last;

  int checks = 0, fails = 0;
  bit stream_on = 1'b0;
  int unsigned data_ctr = 0;
  logic [31:0] beat_q[$];
  logic [7:0]  burst_q[$];   // {rx, beats}
  int cur_n = 0, cur_cnt = 0;

  always #10 clk = ~clk;   // 50 MHz

  dma_burst_seq u0 (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // driver of the stream plus monitor, all sampled mid-cycle
  always @(negedge clk) begin
    in_valid  = stream_on && ($urandom % 4 != 0);
    out_ready = stream_on && ($urandom % 4 != 0);
    in_data   = data_ctr * 32'h9E3779B1 + 32'h01234567;
    #1;
    if (burst_start) begin
      if (burst_q.size() == 0) chk(0, "R9", "unexpected burst", burst_beats, 0);
      else begin
        logic [7:0] e;
        e = burst_q.pop_front();
        chk(burst_rx == e[7] && burst_beats == e[6:0], "R6", "burst {rx,beats}",
            {burst_rx, burst_beats}, e);
      end
      cur_n = burst_beats; cur_cnt = 0;
    end
    if (in_valid && in_ready) begin
      beat_q.push_back(big_endian ? rev(in_data) : in_data);
      data_ctr++;
    end
    if (out_valid && out_ready) begin
      cur_cnt++;
      if (beat_q.size() == 0) chk(0, "R8", "beat without input", out_data, 0);
      else begin
        logic [31:0] e;
        e = beat_q.pop_front();
        chk(out_data == e, "R7", "beat data", out_data, e);
      end
      chk(out_last == (cur_cnt == cur_n), "R8", "out_last", out_last, cur_cnt == cur_n);
    end
  end

  task automatic do_reset();
    stream_on = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_burst(bit rx, int n);
    burst_q.push_back({rx, 7'(n)});
  endtask

  task automatic run(int ntx, int nrx);
    @(negedge clk);
    tx_words = 16'(ntx); rx_words = 16'(nrx);
    tx_req = (ntx > 0); rx_req = (nrx > 0);
    stream_on = 1'b1;
    fork
      begin
        if (ntx > 0) begin
          while (!tx_done) @(negedge clk);
          tx_req = 1'b0;
        end
      end
      begin
        if (nrx > 0) begin
          while (!rx_done) @(negedge clk);
          rx_req = 1'b0;
        end
      end
    join
    repeat (3) @(negedge clk);
    stream_on = 1'b0;
    chk(burst_q.size() == 0, "R6", "bursts outstanding", burst_q.size(), 0);
    burst_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    chk(!burst_start && !out_valid && !in_ready && !tx_done && !rx_done, "R9",
        "reset state", {burst_start, out_valid, in_ready, tx_done, rx_done}, 0);

    // R4: receive first, code 2
    burst_code = 6'h02; fair_mode = 1'b0;
    chk(!code_bad, "R3", "code_bad for 0x02", code_bad, 0);
    expect_burst(1, 2); expect_burst(1, 2); expect_burst(1, 1);
    expect_burst(0, 2); expect_burst(0, 1);
    run(3, 5);

    // R5: alternating grants, code 4
    do_reset();
    fair_mode = 1'b1; burst_code = 6'h04;
    expect_burst(0, 4); expect_burst(1, 4); expect_burst(0, 1); expect_burst(1, 1);
    run(5, 5);

    // R2: cache fallback 3, then 0 -> 1
    fair_mode = 1'b0; burst_code = 6'h00; cache_words = 7'd3;
    #1 chk(!code_bad, "R2", "code_bad for 0x00", code_bad, 0);
    expect_burst(0, 3); expect_burst(0, 3); expect_burst(0, 1);
    run(7, 0);
    cache_words = 7'd0;
    expect_burst(1, 1); expect_burst(1, 1);
    run(0, 2);

    // R3: reserved code
    burst_code = 6'h03;
    #1 chk(code_bad, "R3", "code_bad for 0x03", code_bad, 1);
    expect_burst(1, 1); expect_burst(1, 1);
    run(0, 2);
    burst_code = 6'h30;
    #1 chk(code_bad, "R3", "code_bad for 0x30", code_bad, 1);

    // R1 and R7: large codes with byte reversal
    big_endian = 1'b1; burst_code = 6'h20;
    #1 chk(!code_bad, "R1", "code_bad for 0x20", code_bad, 0);
    expect_burst(0, 32); expect_burst(0, 8);
    run(40, 0);
    burst_code = 6'h10;
    expect_burst(1, 16);
    run(0, 16);
    big_endian = 1'b0; burst_code = 6'h08;
    expect_burst(0, 8); expect_burst(0, 1);
    run(9, 0);
    burst_code = 6'h01;
    expect_burst(1, 1); expect_burst(1, 1);
    run(0, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule